// File: doc/BRIEF.md
# Receive Frame Error Classifier

This block watches the byte stream that an Ethernet receive MAC delivers toward a frame buffer. A start strobe opens each frame, a valid strobe marks each data byte, and an end strobe closes it. The end strobe carries two side inputs: the outcome of the frame check sequence test and the number of leftover bits seen after the last whole byte. The block counts the bytes and tests the frame for a bad check sequence, too few bytes, too many bytes, leftover bits, and misalignment. Misalignment means leftover bits together with a bad check sequence.

Each error class that can reject a frame has its own accept bit in `cfg_accept`. If any error is present whose accept bit is clear, the frame is dropped, and the block raises a discard pulse one cycle after the end strobe. Oversize frames that are accepted are cut off: the write strobe toward the buffer stops after byte 1518. Every detected condition also sets a sticky event bit. A read strobe clears these bits. The interrupt output is the OR of the event bits whose enables are set.

Top module: `rx_err_classifier`

## Requirements
- R1: A frame ending with `rx_crc_bad` high sets flag bit 0 in `res_flags` and in `evt_flags`. The frame is kept only if `cfg_accept[0]` is set.
- R2: A frame of fewer than 64 bytes sets flag bit 1. It is kept only if `cfg_accept[1]` is set.
- R3: A frame of more than 1518 bytes sets flag bit 2. It is kept only if `cfg_accept[2]` is set. `buf_we` is high for at most the first 1518 bytes, and `res_len` reports 1518.
- R4: A nonzero `rx_drib_bits` sets flag bit 3. This condition alone never causes a discard.
- R5: Flag bit 4 (alignment) is set exactly when flag bits 0 and 3 are both set for the same frame.
- R6: A frame of 64 to 1518 bytes with a good check sequence and no leftover bits is kept, and its flags are all zero.
- R7: `res_valid` is high only in the cycle after `rx_eof`. In that cycle `res_discard` equals the inverse of `res_keep`.
- R8: `evt_flags` collects the flags of every frame and holds them until `evt_rd` is asserted. The cycle after `evt_rd`, the register holds only the flags of a frame that ended in the same cycle as the read.
- R9: `irq` is high exactly when some bit of `evt_flags` is set together with the same bit of `cfg_irq_en`.
- R10: The byte count saturates above 1518. A frame far longer than 1518 bytes is still reported as oversize, with `res_len` equal to 1518.
- R11: After reset, `res_valid`, `res_flags`, `evt_flags` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Frame start strobe; clears the byte count |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_eof | input | 1 | Frame end strobe; carries no data byte |
| rx_crc_bad | input | 1 | Check sequence failed; sampled with `rx_eof` |
| rx_drib_bits | input | 3 | Leftover bit count; sampled with `rx_eof` |
| cfg_accept | input | 3 | Accept bits: [0] check sequence, [1] short, [2] oversize |
| cfg_irq_en | input | 5 | Interrupt enable, one bit per flag bit |
| evt_rd | input | 1 | Event register read strobe; clears the register |
| buf_we | output | 1 | Byte write strobe toward the buffer |
| buf_data | output | 8 | Byte toward the buffer |
| res_valid | output | 1 | Classification result valid |
| res_keep | output | 1 | Frame is to be kept |
| res_discard | output | 1 | Frame is to be dropped |
| res_flags | output | 5 | Flags of this frame: [0] check, [1] short, [2] oversize, [3] leftover bits, [4] alignment |
| res_len | output | 11 | Byte count, limited to 1518 |
| evt_flags | output | 5 | Sticky event bits, same layout as `res_flags` |
| irq | output | 1 | Interrupt |

## Verification
The result outputs are registered on the `rx_eof` edge. The bench therefore samples them at the falling edge that follows that rising edge, and checks one cycle later that `res_valid` has dropped again. `buf_we` is a combinational gate of the current byte strobe. It is sampled just after each byte is driven and counted per frame. The event bits and `irq` follow an end or read strobe by one register. The bench samples them only at the falling edge after that strobe has been clocked in.

// File: rtl/rxec_pkg.sv
package rxec_pkg;
    localparam int EVT_N     = 5;
    localparam int EVT_CRC   = 0;
    localparam int EVT_RUNT  = 1;
    localparam int EVT_EXTRA = 2;
    localparam int EVT_DRIB  = 3;
    localparam int EVT_ALIGN = 4;

    localparam int ACC_N     = 3;
    localparam int ACC_CRC   = 0;
    localparam int ACC_RUNT  = 1;
    localparam int ACC_EXTRA = 2;

    typedef logic [EVT_N-1:0] evt_vec_t;
    typedef logic [ACC_N-1:0] acc_vec_t;
endpackage

// File: rtl/rxec_len_cnt.sv
module rxec_len_cnt #(
    parameter int MAX_LEN = 1518,
    parameter int LEN_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    output logic [LEN_W-1:0] cnt,
    output logic             room
);
    localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] SAT = LEN_W'(MAX_LEN + 1);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (byte_vld && (st_q.cnt != SAT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign room = (st_q.cnt < LIM);
endmodule

// File: rtl/rxec_classify.sv
module rxec_classify
    import rxec_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int LEN_W   = 11,
    parameter int DRIB_W  = 3
) (
    input  logic [LEN_W-1:0]  cnt,
    input  logic              crc_bad,
    input  logic [DRIB_W-1:0] drib_bits,
    input  acc_vec_t          accept,
    output evt_vec_t          flags,
    output logic              keep,
    output logic [LEN_W-1:0]  len
);
    localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);

    logic runt, extra, drib;

    always_comb begin
        runt  = (cnt < MIN_V);
        extra = (cnt > MAX_V);
        drib  = |drib_bits;

        flags            = '0;
        flags[EVT_CRC]   = crc_bad;
        flags[EVT_RUNT]  = runt;
        flags[EVT_EXTRA] = extra;
        flags[EVT_DRIB]  = drib;
        flags[EVT_ALIGN] = crc_bad & drib;

        keep = !((crc_bad && !accept[ACC_CRC])  ||
                 (runt    && !accept[ACC_RUNT]) ||
                 (extra   && !accept[ACC_EXTRA]));

        len = extra ? MAX_V : cnt;
    end
endmodule

// File: rtl/rxec_evt_reg.sv
module rxec_evt_reg
    import rxec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     set_vld,
    input  evt_vec_t set_flags,
    input  logic     rd,
    input  evt_vec_t irq_en,
    output evt_vec_t flags,
    output logic     irq
);
    typedef struct packed {
        evt_vec_t flags;
    } st_t;

    st_t      st_d, st_q;
    evt_vec_t nxt;

    for (genvar g = 0; g < EVT_N; g++) begin : g_bit
        assign nxt[g] = (rd ? 1'b0 : st_q.flags[g]) | (set_vld & set_flags[g]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign irq   = |(st_q.flags & irq_en);
endmodule

// File: rtl/rx_err_classifier.sv
module rx_err_classifier
    import rxec_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int DRIB_W  = 3,
    parameter int DATA_W  = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_eof,
    input  logic              rx_crc_bad,
    input  logic [DRIB_W-1:0] rx_drib_bits,
    input  logic [ACC_N-1:0]  cfg_accept,
    input  logic [EVT_N-1:0]  cfg_irq_en,
    input  logic              evt_rd,
    output logic              buf_we,
    output logic [DATA_W-1:0] buf_data,
    output logic              res_valid,
    output logic              res_keep,
    output logic              res_discard,
    output logic [EVT_N-1:0]  res_flags,
    output logic [LEN_W-1:0]  res_len,
    output logic [EVT_N-1:0]  evt_flags,
    output logic              irq
);
    typedef struct packed {
        logic             valid;
        logic             keep;
        logic             discard;
        evt_vec_t         flags;
        logic [LEN_W-1:0] len;
    } res_t;

    logic [LEN_W-1:0] cnt;
    logic             room;
    evt_vec_t         cls_flags;
    logic             cls_keep;
    logic [LEN_W-1:0] cls_len;
    res_t             res_d, res_q;

    rxec_len_cnt #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_sof | rx_eof),
        .byte_vld (rx_valid),
        .cnt      (cnt),
        .room     (room)
    );

    rxec_classify #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .DRIB_W  (DRIB_W)
    ) u_cls (
        .cnt       (cnt),
        .crc_bad   (rx_crc_bad),
        .drib_bits (rx_drib_bits),
        .accept    (cfg_accept),
        .flags     (cls_flags),
        .keep      (cls_keep),
        .len       (cls_len)
    );

    rxec_evt_reg u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld   (rx_eof),
        .set_flags (cls_flags),
        .rd        (evt_rd),
        .irq_en    (cfg_irq_en),
        .flags     (evt_flags),
        .irq       (irq)
    );

    always_comb begin
        res_d = '0;
        if (rx_eof) begin
            res_d.valid   = 1'b1;
            res_d.keep    = cls_keep;
            res_d.discard = !cls_keep;
            res_d.flags   = cls_flags;
            res_d.len     = cls_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign buf_we      = rx_valid & room;
    assign buf_data    = rx_data;
    assign res_valid   = res_q.valid;
    assign res_keep    = res_q.keep;
    assign res_discard = res_q.discard;
    assign res_flags   = res_q.flags;
    assign res_len     = res_q.len;
endmodule

// File: rtl/rxec_checker.sv
module rxec_checker
    import rxec_pkg::*;
#(
    parameter int MAX_LEN = 1518,
    parameter int DRIB_W  = 3,
    parameter int DATA_W  = 8,
    parameter int LEN_W   = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_sof,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_eof,
    input logic              rx_crc_bad,
    input logic [DRIB_W-1:0] rx_drib_bits,
    input logic [ACC_N-1:0]  cfg_accept,
    input logic [EVT_N-1:0]  cfg_irq_en,
    input logic              evt_rd,
    input logic              buf_we,
    input logic [DATA_W-1:0] buf_data,
    input logic              res_valid,
    input logic              res_keep,
    input logic              res_discard,
    input logic [EVT_N-1:0]  res_flags,
    input logic [LEN_W-1:0]  res_len,
    input logic [EVT_N-1:0]  evt_flags,
    input logic              irq
);
    a_r1_crc_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && rx_crc_bad && !cfg_accept[ACC_CRC]) |=> (res_discard && res_flags[EVT_CRC]));

    a_r4_drib_alone_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && !rx_crc_bad && (rx_drib_bits != '0) && (&cfg_accept)) |=> res_keep);

    a_r5_align_pair: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_flags[EVT_ALIGN] == (res_flags[EVT_CRC] && res_flags[EVT_DRIB])));

    a_r7_valid_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |=> res_valid);

    a_r7_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_eof |=> !res_valid);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_rd |=> ((evt_flags & $past(evt_flags)) == $past(evt_flags)));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && !rx_eof) |=> (evt_flags == '0 && !irq));

    a_r10_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_len <= LEN_W'(MAX_LEN)));

    a_r3_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> rx_valid);
endmodule

bind rx_err_classifier rxec_checker #(
    .MAX_LEN (MAX_LEN),
    .DRIB_W  (DRIB_W),
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W)
) u_chk (.*);

// File: tb/rx_err_classifier_bench.sv
module rx_err_classifier_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_crc_bad = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_drib_bits = '0;
    logic [2:0] cfg_accept = '0;
    logic [4:0] cfg_irq_en = '0;
    logic       evt_rd = 1'b0;
    logic       buf_we, res_valid, res_keep, res_discard, irq;
    logic [7:0] buf_data;
    logic [4:0] res_flags, evt_flags;
    logic [10:0] res_len;

    int nvec = 0;
    int nfail = 0;
    int wcnt = 0;

    always #5 clk = ~clk;

    rx_err_classifier u_rx_err_classifier (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .rx_crc_bad(rx_crc_bad),
        .rx_drib_bits(rx_drib_bits), .cfg_accept(cfg_accept),
        .cfg_irq_en(cfg_irq_en), .evt_rd(evt_rd), .buf_we(buf_we),
        .buf_data(buf_data), .res_valid(res_valid), .res_keep(res_keep),
        .res_discard(res_discard), .res_flags(res_flags), .res_len(res_len),
        .evt_flags(evt_flags), .irq(irq)
    );

    typedef struct packed {
        int       len;
        bit       crc;
        bit [2:0] drib;
        bit [2:0] acc;
        bit       keep;
        bit [4:0] flags;
        int       elen;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{64,   1'b0, 3'd0, 3'b000, 1'b1, 5'h00, 64},
        '{1518, 1'b0, 3'd0, 3'b000, 1'b1, 5'h00, 1518},
        '{63,   1'b0, 3'd0, 3'b000, 1'b0, 5'h02, 63},
        '{63,   1'b0, 3'd0, 3'b010, 1'b1, 5'h02, 63},
        '{100,  1'b1, 3'd0, 3'b000, 1'b0, 5'h01, 100},
        '{100,  1'b1, 3'd0, 3'b001, 1'b1, 5'h01, 100},
        '{100,  1'b0, 3'd3, 3'b000, 1'b1, 5'h08, 100},
        '{100,  1'b1, 3'd5, 3'b000, 1'b0, 5'h19, 100},
        '{100,  1'b1, 3'd7, 3'b001, 1'b1, 5'h19, 100},
        '{1519, 1'b0, 3'd0, 3'b000, 1'b0, 5'h04, 1518},
        '{1519, 1'b0, 3'd0, 3'b100, 1'b1, 5'h04, 1518},
        '{2000, 1'b0, 3'd0, 3'b100, 1'b1, 5'h04, 1518},
        '{10,   1'b1, 3'd0, 3'b001, 1'b0, 5'h03, 10},
        '{0,    1'b0, 3'd0, 3'b010, 1'b1, 5'h02, 0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One frame; on return the falling edge after the end strobe has been reached.
    task automatic send_frame(input int len, input bit crc, input bit [2:0] drib, input bit rd_at_end);
        wcnt = 0;
        @(negedge clk);
        rx_sof = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(i);
            #1;
            if (buf_we) wcnt++;
            @(negedge clk);
        end
        rx_valid     = 1'b0;
        rx_eof       = 1'b1;
        rx_crc_bad   = crc;
        rx_drib_bits = drib;
        evt_rd       = rd_at_end;
        @(negedge clk);
        rx_eof       = 1'b0;
        rx_crc_bad   = 1'b0;
        rx_drib_bits = '0;
        evt_rd       = 1'b0;
    endtask

    task automatic read_evt();
        @(negedge clk);
        evt_rd = 1'b1;
        @(negedge clk);
        evt_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [4:0] acc_flags;
        acc_flags = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 res_valid", res_valid, 0);
        chk("R11 res_flags", res_flags, 0);
        chk("R11 evt_flags", evt_flags, 0);
        chk("R11 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            cfg_accept = TBL[v].acc;
            send_frame(TBL[v].len, TBL[v].crc, TBL[v].drib, 1'b0);
            acc_flags = acc_flags | TBL[v].flags;
            chk("R7 res_valid", res_valid, 1);
            chk("R1/R2/R3/R4/R5 res_flags", res_flags, TBL[v].flags);
            chk("R1/R2/R3/R6 res_keep", res_keep, TBL[v].keep);
            chk("R7 res_discard", res_discard, !TBL[v].keep);
            chk("R3/R10 res_len", res_len, TBL[v].elen);
            chk("R3 buffer writes", wcnt, (TBL[v].len > 1518) ? 1518 : TBL[v].len);
            @(negedge clk);
            chk("R7 res_valid drops", res_valid, 0);
            chk("R7 res_discard drops", res_discard, 0);
        end

        // R8: all frames collected; R9: no enable, no interrupt
        chk("R8 sticky collect", evt_flags, acc_flags);
        chk("R9 irq masked", irq, 0);
        cfg_irq_en = 5'h01;
        #1;
        chk("R9 irq enabled", irq, 1);

        read_evt();
        chk("R8 cleared by read", evt_flags, 0);
        chk("R9 irq after clear", irq, 0);

        cfg_accept = 3'b111;
        send_frame(20, 1'b0, 3'd0, 1'b0);
        chk("R2 short event", evt_flags, 5'h02);
        chk("R9 irq other bit", irq, 0);
        cfg_irq_en = 5'h02;
        #1;
        chk("R9 irq matching bit", irq, 1);

        // R8: read in the same cycle as a frame end keeps the new flags
        send_frame(100, 1'b1, 3'd0, 1'b1);
        chk("R8 read with end", evt_flags, 5'h01);
        chk("R1 kept when accepted", res_keep, 1);
        chk("R9 irq after read", irq, 0);

        // R6: error-free frame after accept bits cleared
        cfg_accept = 3'b000;
        send_frame(300, 1'b0, 3'd0, 1'b0);
        chk("R6 clean keep", res_keep, 1);
        chk("R6 clean flags", res_flags, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule